// File: doc/BRIEF.md
# Free List Return Write Handler

This block takes host writes that hand back empty message-frame addresses and turns each into a write to the tail of a circular free list kept in local memory. A host write is taken at once into a four-entry posted queue. When it is taken, the block stamps it with the memory address of the current tail slot and moves the tail forward. The queue then drains in order to a request/acknowledge memory write port.

A free-entry counter counts the writes that have actually landed in memory. It rises on each memory acknowledge and falls on a strobe from the local consumer that takes entries off the list. The list length is chosen from eight power-of-two sizes. The base address is forced onto that size's boundary, so the tail wraps in hardware with no software help.

Top module: `free_list_return`

## Requirements
- R1: After a synchronous active-high reset, `tail_idx` is 0, `free_cnt` is 0, `m_req` is 0 and `h_wready` is 1.
- R2: A host write is accepted on a clock edge where `h_wvalid` and `h_wready` are both high. `tail_idx` moves forward by one at that same edge, before the memory write completes.
- R3: An accepted write is sent to `m_addr` = (`list_base` with its low log2(entries)+2 bits cleared) OR (`tail_idx` × 4). The tail value used is the one in place at the accept edge. `m_data` equals the accepted `h_wdata`.
- R4: Queued writes go to the memory port strictly in the order they were accepted.
- R5: With four writes pending, `h_wready` is 0 and no write is accepted. A write held on `h_wvalid` is taken, unchanged, once a slot frees up.
- R6: `free_cnt` goes up by one at each edge where `m_req` and `m_ack` are both high, and does not change when a write is merely accepted.
- R7: A high `dec_stb` lowers `free_cnt` by one. `dec_stb` together with a completion leaves `free_cnt` unchanged. `dec_stb` alone at zero leaves it at zero.
- R8: The list has 256 × 2^`size_sel` entries (`size_sel` 0..7 gives 256..32K). Past the last index, `tail_idx` wraps to 0.
- R9: While `m_req` is high and `m_ack` is low, `m_req`, `m_addr` and `m_data` hold steady on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 3 | List size select, entries = 256 << size_sel |
| list_base | input | 32 | List base byte address; bits below the list's byte size are ignored |
| h_wvalid | input | 1 | Host write offered |
| h_wdata | input | 32 | Returned frame address to append |
| h_wready | output | 1 | Posted queue has room |
| m_req | output | 1 | Memory write request |
| m_addr | output | 32 | Memory write byte address |
| m_data | output | 32 | Memory write data |
| m_ack | input | 1 | Memory write completed (meaningful only while m_req is high) |
| dec_stb | input | 1 | Local consumer removed one entry |
| tail_idx | output | 15 | Current tail index |
| free_cnt | output | 16 | Entries written to memory and not yet consumed |

## Verification
The assertions take for granted that `m_ack` comes only while `m_req` is high. They also assume that `size_sel` and `list_base` stay fixed while writes are pending, so a queued address never refers to a different layout. The bench raises `m_ack` only after it has seen `m_req` at a falling edge. It changes the size and base only right after a reset, with the queue empty. The host side holds `h_wvalid` and `h_wdata` steady until the write is accepted, which is what the stall check depends on.

// File: rtl/flr_pkg.sv
package flr_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = 3;
    localparam int MIN_LOG = 8;
    localparam int IDX_W   = MIN_LOG + (1 << SEL_W) - 1;
    localparam int CNT_W   = IDX_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } flr_entry_t;

    // index mask for the selected list length
    function automatic logic [IDX_W-1:0] idx_mask(input logic [SEL_W-1:0] sel);
        logic [IDX_W:0] full;
        full = ((IDX_W+1)'(1) << (MIN_LOG + int'(sel))) - (IDX_W+1)'(1);
        return full[IDX_W-1:0];
    endfunction

    // byte address of a tail slot inside an aligned list
    function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [SEL_W-1:0]  sel,
                                                   input logic [IDX_W-1:0]  idx);
        logic [ADDR_W-1:0] bmask;
        bmask = ADDR_W'({idx_mask(sel), 2'b11});
        return (base & ~bmask) | ADDR_W'({idx, 2'b00});
    endfunction

endpackage

// File: rtl/flr_tail.sv
module flr_tail
    import flr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  size_sel,
    input  logic [ADDR_W-1:0] list_base,
    input  logic              advance,
    output logic [IDX_W-1:0]  tail,
    output logic [ADDR_W-1:0] tail_addr
);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] tail_q;

    assign mask = idx_mask(size_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
        end else if (advance) begin
            tail_q <= (tail_q + IDX_W'(1)) & mask;
        end
    end

    assign tail      = tail_q;
    assign tail_addr = slot_addr(list_base, size_sel, tail_q);

    // R2: tail steps by one (mod size) on every accepted write
    a_r2_tail_step: assert property (@(posedge clk) disable iff (rst)
        advance |=> tail_q == (($past(tail_q) + IDX_W'(1)) & $past(mask)));

    // R8: tail stays inside the selected list
    a_r8_tail_in_range: assert property (@(posedge clk) disable iff (rst)
        $stable(size_sel) |-> ((tail_q & ~mask) == '0));

endmodule

// File: rtl/flr_queue.sv
module flr_queue
    import flr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  flr_entry_t push_ent,
    input  logic       pop,
    output flr_entry_t head,
    output logic       full,
    output logic       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W_Q = PTR_W + 1;

    flr_entry_t          store [DEPTH];
    logic [PTR_W-1:0]    wr_ptr;
    logic [PTR_W-1:0]    rd_ptr;
    logic [CNT_W_Q-1:0]  level;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full  = (level == CNT_W_Q'(DEPTH));
    assign empty = (level == '0);
    assign head  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   level <= level + CNT_W_Q'(1);
                2'b01:   level <= level - CNT_W_Q'(1);
                default: level <= level;
            endcase
        end
    end

    // R5: never written while full
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/flr_counter.sv
module flr_counter
    import flr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;
    logic             at_zero;

    assign at_max  = (cnt_q == '1);
    assign at_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (!at_max)  cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   if (!at_zero) cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

    // R6: a completion alone raises the count
    a_r6_count_up: assert property (@(posedge clk) disable iff (rst)
        (inc && !dec && !at_max) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R7: completion and strobe together cancel
    a_r7_cancel: assert property (@(posedge clk) disable iff (rst)
        (inc && dec) |=> $stable(cnt_q));

    // R7: strobe at zero leaves zero
    a_r7_floor: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && at_zero) |=> cnt_q == '0);

endmodule

// File: rtl/free_list_return.sv
module free_list_return
    import flr_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEL_W-1:0]      size_sel,
    input  logic [ADDR_W-1:0]     list_base,
    input  logic                  h_wvalid,
    input  logic [DATA_W-1:0]     h_wdata,
    output logic                  h_wready,
    output logic                  m_req,
    output logic [ADDR_W-1:0]     m_addr,
    output logic [DATA_W-1:0]     m_data,
    input  logic                  m_ack,
    input  logic                  dec_stb,
    output logic [IDX_W-1:0]      tail_idx,
    output logic [CNT_W-1:0]      free_cnt
);
    logic              q_full;
    logic              q_empty;
    logic              accept;
    logic              done;
    logic [ADDR_W-1:0] slot;
    flr_entry_t        new_ent;
    flr_entry_t        head_ent;

    assign h_wready = !q_full;
    assign accept   = h_wvalid && !q_full;
    assign done     = m_ack && !q_empty;

    flr_tail u_tail (
        .clk       (clk),
        .rst       (rst),
        .size_sel  (size_sel),
        .list_base (list_base),
        .advance   (accept),
        .tail      (tail_idx),
        .tail_addr (slot)
    );

    always_comb begin
        new_ent.addr = slot;
        new_ent.data = h_wdata;
    end

    flr_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_ent (new_ent),
        .pop      (done),
        .head     (head_ent),
        .full     (q_full),
        .empty    (q_empty)
    );

    assign m_req  = !q_empty;
    assign m_addr = head_ent.addr;
    assign m_data = head_ent.data;

    flr_counter u_count (
        .clk   (clk),
        .rst   (rst),
        .inc   (done),
        .dec   (dec_stb),
        .count (free_cnt)
    );

    // R9: request held with stable payload until acknowledged
    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_data)));

    // R6: accepting a write alone does not move the count
    a_r6_no_early_count: assert property (@(posedge clk) disable iff (rst)
        (accept && !done && !dec_stb) |=> $stable(free_cnt));

    // R5: a stalled offer leaves the tail alone
    a_r5_stall_holds_tail: assert property (@(posedge clk) disable iff (rst)
        (h_wvalid && !h_wready) |=> $stable(tail_idx));

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (tail_idx == '0 && free_cnt == '0 && !m_req && h_wready));

endmodule

// File: tb/sim_free_list_return.sv
module sim_free_list_return;
    import flr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [SEL_W-1:0]  size_sel = '0;
    logic [ADDR_W-1:0] list_base = '0;
    logic              h_wvalid = 1'b0;
    logic [DATA_W-1:0] h_wdata = '0;
    logic              h_wready;
    logic              m_req;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_data;
    logic              m_ack = 1'b0;
    logic              dec_stb = 1'b0;
    logic [IDX_W-1:0]  tail_idx;
    logic [CNT_W-1:0]  free_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    free_list_return u0 (
        .clk(clk), .rst(rst), .size_sel(size_sel), .list_base(list_base),
        .h_wvalid(h_wvalid), .h_wdata(h_wdata), .h_wready(h_wready),
        .m_req(m_req), .m_addr(m_addr), .m_data(m_data), .m_ack(m_ack),
        .dec_stb(dec_stb), .tail_idx(tail_idx), .free_cnt(free_cnt)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                   input int sel, input int idx);
        longint bytes;
        bytes = longint'(256) << sel;
        bytes = bytes * 4;
        return ADDR_W'((longint'(b) & ~(bytes - 1)) | (longint'(idx) * 4));
    endfunction

    task automatic do_reset(input int sel, input logic [ADDR_W-1:0] b);
        @(negedge clk);
        rst = 1'b1; size_sel = SEL_W'(sel); list_base = b;
        h_wvalid = 1'b0; m_ack = 1'b0; dec_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // offer a write, hold until accepted; returns at negedge after accept edge
    task automatic push(input logic [DATA_W-1:0] d);
        h_wvalid = 1'b1; h_wdata = d;
        while (!h_wready) @(negedge clk);
        @(negedge clk);
        h_wvalid = 1'b0;
    endtask

    task automatic drain(input string req, input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] ed);
        check({req, " req"}, 64'(m_req), 64'd1);
        check({req, " addr"}, 64'(m_addr), 64'(ea));
        check({req, " data"}, 64'(m_data), 64'(ed));
        m_ack = 1'b1;
        @(negedge clk);
        m_ack = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(0, 32'h1000_0000);
        check("R1 tail", 64'(tail_idx), 0);
        check("R1 cnt", 64'(free_cnt), 0);
        check("R1 req", 64'(m_req), 0);
        check("R1 ready", 64'(h_wready), 1);
    endtask

    task automatic t_single;
        do_reset(0, 32'h1000_0000);
        push(32'hAAAA_0001);
        check("R2 tail after accept", 64'(tail_idx), 1);
        check("R6 cnt not moved by accept", 64'(free_cnt), 0);
        // R9: hold without ack for two cycles
        @(negedge clk);
        @(negedge clk);
        drain("R3 R9 single", exp_addr(32'h1000_0000, 0, 0), 32'hAAAA_0001);
        check("R6 cnt after ack", 64'(free_cnt), 1);
        check("R6 req drops", 64'(m_req), 0);
    endtask

    task automatic t_full_order;
        do_reset(0, 32'h2000_0000);
        for (int i = 0; i < 4; i++) push(32'hB000_0000 + i);
        check("R5 ready low when full", 64'(h_wready), 0);
        check("R2 tail after four", 64'(tail_idx), 4);
        h_wvalid = 1'b1; h_wdata = 32'hB000_0004;
        @(negedge clk);
        @(negedge clk);
        check("R5 stalled write not taken", 64'(tail_idx), 4);
        drain("R4 first", exp_addr(32'h2000_0000, 0, 0), 32'hB000_0000);
        // held write accepted at this edge since ready rose
        @(negedge clk);
        h_wvalid = 1'b0;
        check("R5 held write taken", 64'(tail_idx), 5);
        for (int i = 1; i < 5; i++)
            drain("R4 order", exp_addr(32'h2000_0000, 0, i), 32'hB000_0000 + i);
        check("R6 cnt after five", 64'(free_cnt), 5);
    endtask

    task automatic t_decrement;
        do_reset(0, 32'h3000_0000);
        push(32'h1); push(32'h2);
        drain("R6 a", exp_addr(32'h3000_0000, 0, 0), 32'h1);
        check("R6 cnt one", 64'(free_cnt), 1);
        // completion + strobe together
        m_ack = 1'b1; dec_stb = 1'b1;
        @(negedge clk);
        m_ack = 1'b0; dec_stb = 1'b0;
        check("R7 cancel", 64'(free_cnt), 1);
        dec_stb = 1'b1;
        @(negedge clk);
        check("R7 dec", 64'(free_cnt), 0);
        @(negedge clk);
        dec_stb = 1'b0;
        check("R7 floor", 64'(free_cnt), 0);
    endtask

    task automatic t_wrap;
        do_reset(0, 32'h4000_0000);
        for (int i = 0; i < 256; i++) begin
            push(32'hC000_0000 + i);
            if (i == 255 || i == 0)
                drain("R8 R3 wrap path", exp_addr(32'h4000_0000, 0, i), 32'hC000_0000 + i);
            else begin
                m_ack = 1'b1; @(negedge clk); m_ack = 1'b0;
            end
        end
        check("R8 tail wrapped", 64'(tail_idx), 0);
        push(32'hC000_0100);
        drain("R8 after wrap", exp_addr(32'h4000_0000, 0, 0), 32'hC000_0100);
        check("R6 cnt after wrap", 64'(free_cnt), 257);
    endtask

    task automatic t_align;
        do_reset(1, 32'h5000_07FC);
        push(32'hD1);
        push(32'hD2);
        drain("R3 aligned base", exp_addr(32'h5000_07FC, 1, 0), 32'hD1);
        drain("R3 aligned base 2", exp_addr(32'h5000_07FC, 1, 1), 32'hD2);
        do_reset(7, 32'h0001_2344);
        push(32'hE1);
        drain("R3 largest size", exp_addr(32'h0001_2344, 7, 0), 32'hE1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_full_order();
        t_decrement();
        t_wrap();
        t_align();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule